// File: doc/BRIEF.md
# Byte/Nibble I/Q Word Assembler

This block sits behind the input capture of a dual-channel converter data path. Each clock cycle it takes one narrow transfer from a single data lane and collects the transfers into one 32-bit word that holds a 16-bit I sample and a 16-bit Q sample. The finished word is handed to a FIFO write port. The lane runs in one of two modes, selected by `nibble_mode`:

- **Byte mode** uses four transfers per I/Q pair.
- **Nibble mode** uses eight transfers per I/Q pair, and only the low four lane bits carry data.

A frame marker, `frame_in`, shows where each load starts. A rising frame marker forces the sample it arrives with into the first slot. If the marker stays high for every sample of a whole load (an extended frame), the block raises a one-cycle request to reset the FIFO pointers. If the lane mode changes, any half-built word is thrown away and the slot counter starts again.

The frame detector is a three-state machine:

| State | Meaning | Transitions |
|---|---|---|
| `FR_LOW` | Marker idle | Marker high: this is the rise. It realigns the slot counter and moves to `FR_RUN` with a run count of 1. |
| `FR_RUN` | Counting a high run | Marker low: back to `FR_LOW`. Run reaches the load length: the request fires and the state moves to `FR_HELD`. Otherwise the count goes up by one. |
| `FR_HELD` | Request already given | Stays here until the marker drops, then returns to `FR_LOW`. |

A mode change overrides all of the above. The next state is `FR_HELD` if the marker is high at that moment, and `FR_LOW` if it is low.

Top module: `iq_word_assembler`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `word_valid` and `fifo_reset_req` are 0 and `word_out` is 0. The slot counter starts at the first slot.
- R2: In byte mode (`nibble_mode`=0) the four transfers are placed into `word_out` in this order:
  - I high byte into bits [31:24]
  - I low byte into bits [23:16]
  - Q high byte into bits [15:8]
  - Q low byte into bits [7:0]
- R3: In nibble mode (`nibble_mode`=1) transfer k, for k = 0 to 7, puts `lane_in[3:0]` into bits [31-4k:28-4k]. This gives I nibbles 3 down to 0, then Q nibbles 3 down to 0. `lane_in[7:4]` is ignored.
- R4: `word_valid` is high for exactly one cycle. That is the cycle after the last transfer of a load, and the completed word appears on `word_out` in the same cycle.
- R5: A sample that arrives with a rising `frame_in` (high now, low on the previous sample) is taken as the first slot of a new load. A marker that is high for fewer samples than a load does not raise `fifo_reset_req`.
- R6: When `frame_in` rises and stays high for a whole load, `fifo_reset_req` pulses for one cycle. That is 4 samples in byte mode and 8 in nibble mode. The pulse comes in the same cycle as that load's `word_valid`.
- R7: While `frame_in` stays high after a request, no further request is raised, however many loads go by.
- R8: `word_out` holds its value in every cycle where `word_valid` is 0.
- R9: A sample that arrives while `nibble_mode` differs from its value on the previous sample is discarded. Any partial word is dropped, and the next sample fills the first slot. `word_valid` is 0 in the cycle after the change. A marker that is already high across the change does not count as a rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; one transfer per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| nibble_mode | input | 1 | 0 = byte lane, 1 = nibble lane |
| lane_in | input | 8 | Transfer data; only bits [3:0] are used in nibble mode |
| frame_in | input | 1 | Frame marker sampled with each transfer |
| word_out | output | 32 | Assembled word: I in [31:16], Q in [15:0] |
| word_valid | output | 1 | One-cycle strobe when `word_out` holds a new word |
| fifo_reset_req | output | 1 | One-cycle FIFO pointer reset request |

## Verification
A slot counter out of step shows up as rotated bytes or nibbles on `word_out`, and as `word_valid` landing at the wrong point. Both are visible at the next strobe, within one load: four cycles in byte mode, eight in nibble mode. A wrong frame-detector state shows up at the end of the load in question. It appears as a missing request, an extra request, or a request that does not line up with `word_valid`. If a mode change leaves stale data behind, the first word after the change has the wrong bytes.

// File: rtl/iq_asm_pkg.sv
package iq_asm_pkg;
    typedef enum logic [1:0] {
        FR_LOW  = 2'd0,
        FR_RUN  = 2'd1,
        FR_HELD = 2'd2
    } frame_state_e;
endpackage

// File: rtl/iq_frame_fsm.sv
module iq_frame_fsm
    import iq_asm_pkg::*;
#(
    parameter int BYTE_SLOTS = 4,
    parameter int NIB_SLOTS  = 8,
    parameter int CNT_W      = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nibble_mode,
    input  logic mode_chg,
    input  logic frame_in,
    output logic rise,
    output logic reset_req
);
    frame_state_e state_q, state_d;
    logic [CNT_W-1:0] run_q, run_d, need;
    logic req_d;

    assign need = nibble_mode ? CNT_W'(NIB_SLOTS - 1) : CNT_W'(BYTE_SLOTS - 1);

    // next-state and output decode
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        req_d   = 1'b0;
        rise    = 1'b0;
        unique case (state_q)
            FR_LOW: begin
                if (frame_in) begin
                    rise    = 1'b1;
                    run_d   = CNT_W'(1);
                    state_d = FR_RUN;
                end
            end
            FR_RUN: begin
                if (!frame_in) begin
                    state_d = FR_LOW;
                end else if (run_q == need) begin
                    req_d   = 1'b1;
                    state_d = FR_HELD;
                end else begin
                    run_d = run_q + CNT_W'(1);
                end
            end
            FR_HELD: begin
                if (!frame_in) state_d = FR_LOW;
            end
            default: state_d = FR_LOW;
        endcase
        if (mode_chg) begin
            rise    = 1'b0;
            req_d   = 1'b0;
            run_d   = '0;
            state_d = frame_in ? FR_HELD : FR_LOW;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_LOW;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // registered output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reset_req <= 1'b0;
        else        reset_req <= req_d;
    end

    // R7: a request never follows itself
    assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R5: a marker that drops ends the run, so no request can follow
    assert_no_req_after_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_in) |=> !reset_req);
endmodule

// File: rtl/iq_slot_packer.sv
module iq_slot_packer #(
    parameter int LANE_W     = 8,
    parameter int DATA_W     = 32,
    parameter int BYTE_SLOTS = 4,
    parameter int NIB_SLOTS  = 8,
    parameter int CNT_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nibble_mode,
    input  logic              mode_chg,
    input  logic              rise,
    input  logic [LANE_W-1:0] lane_in,
    output logic [DATA_W-1:0] word_out,
    output logic              word_valid
);
    localparam int NIB_W = LANE_W / 2;

    logic [CNT_W-1:0]  slot_q, cur_slot, last_slot;
    logic [DATA_W-1:0] acc_q, shifted;

    assign cur_slot  = rise ? '0 : slot_q;
    assign last_slot = nibble_mode ? CNT_W'(NIB_SLOTS - 1) : CNT_W'(BYTE_SLOTS - 1);
    assign shifted   = nibble_mode ? {acc_q[DATA_W-NIB_W-1:0], lane_in[NIB_W-1:0]}
                                   : {acc_q[DATA_W-LANE_W-1:0], lane_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q     <= '0;
            acc_q      <= '0;
            word_out   <= '0;
            word_valid <= 1'b0;
        end else if (mode_chg) begin
            slot_q     <= '0;
            word_valid <= 1'b0;
        end else begin
            acc_q <= shifted;
            if (cur_slot == last_slot) begin
                slot_q     <= '0;
                word_out   <= shifted;
                word_valid <= 1'b1;
            end else begin
                slot_q     <= cur_slot + CNT_W'(1);
                word_valid <= 1'b0;
            end
        end
    end

    // R4: the strobe lasts a single cycle
    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R8: the word only moves together with the strobe
    assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_valid) |-> $stable(word_out));
endmodule

// File: rtl/iq_word_assembler.sv
module iq_word_assembler #(
    parameter int LANE_W   = 8,
    parameter int SAMPLE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  nibble_mode,
    input  logic [LANE_W-1:0]     lane_in,
    input  logic                  frame_in,
    output logic [2*SAMPLE_W-1:0] word_out,
    output logic                  word_valid,
    output logic                  fifo_reset_req
);
    localparam int DATA_W     = 2 * SAMPLE_W;
    localparam int BYTE_SLOTS = DATA_W / LANE_W;
    localparam int NIB_SLOTS  = 2 * BYTE_SLOTS;
    localparam int CNT_W      = $clog2(NIB_SLOTS);

    logic mode_q, mode_chg, rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= nibble_mode;
    end
    assign mode_chg = (nibble_mode != mode_q);

    iq_frame_fsm #(
        .BYTE_SLOTS(BYTE_SLOTS), .NIB_SLOTS(NIB_SLOTS), .CNT_W(CNT_W)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .nibble_mode(nibble_mode), .mode_chg(mode_chg),
        .frame_in(frame_in), .rise(rise), .reset_req(fifo_reset_req)
    );

    iq_slot_packer #(
        .LANE_W(LANE_W), .DATA_W(DATA_W), .BYTE_SLOTS(BYTE_SLOTS),
        .NIB_SLOTS(NIB_SLOTS), .CNT_W(CNT_W)
    ) u_pack (
        .clk(clk), .rst_n(rst_n), .nibble_mode(nibble_mode), .mode_chg(mode_chg),
        .rise(rise), .lane_in(lane_in), .word_out(word_out), .word_valid(word_valid)
    );

    // R6: a reset request always coincides with the end of a load
    assert_req_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_reset_req |-> word_valid);

    // R9: a mode change yields no word on the following cycle
    assert_mode_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nibble_mode != $past(nibble_mode)) |=> !word_valid);
endmodule

// File: tb/iq_word_assembler_bench.sv
module iq_word_assembler_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        nibble_mode;
    logic [7:0]  lane_in;
    logic        frame_in;
    logic [31:0] word_out;
    logic        word_valid;
    logic        fifo_reset_req;

    iq_word_assembler u_iq_word_assembler (
        .clk(clk), .rst_n(rst_n), .nibble_mode(nibble_mode), .lane_in(lane_in),
        .frame_in(frame_in), .word_out(word_out), .word_valid(word_valid),
        .fifo_reset_req(fifo_reset_req)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference state, built from the requirements
    bit         m_mode;
    int         m_slot;
    logic [3:0] m_nib [8];
    logic [7:0] m_byt [4];
    bit         m_prev_frame;
    int         m_run;
    logic [31:0] m_word;
    bit         e_valid, e_req;
    int         req_seen;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] compose(input bit nib);
        logic [31:0] w = '0;
        if (nib) for (int k = 0; k < 8; k++) w[31-4*k -: 4] = m_nib[k];
        else     for (int k = 0; k < 4; k++) w[31-8*k -: 8] = m_byt[k];
        return w;
    endfunction

    task automatic model(input bit mode, input logic [7:0] lane, input bit fr);
        int n = mode ? 8 : 4;
        bit rise;
        e_valid = 0;
        e_req   = 0;
        if (mode != m_mode) begin
            m_mode = mode;
            m_slot = 0;
            m_run  = 0;
            m_prev_frame = fr;
            return;
        end
        rise = fr && !m_prev_frame;
        if (rise) m_slot = 0;
        if (mode) m_nib[m_slot] = lane[3:0];
        else      m_byt[m_slot] = lane;
        if (m_slot == n - 1) begin
            e_valid = 1;
            m_word  = compose(mode);
            m_slot  = 0;
        end else m_slot++;
        if (!fr) m_run = 0;
        else if (rise) m_run = 1;
        else if (m_run > 0 && m_run < n + 1) m_run++;
        if (fr && m_run == n) e_req = 1;
        m_prev_frame = fr;
    endtask

    task automatic step(input bit mode, input logic [7:0] lane, input bit fr);
        nibble_mode = mode;
        lane_in     = lane;
        frame_in    = fr;
        model(mode, lane, fr);
        @(posedge clk);
        #2;
        check("word_valid", {31'd0, word_valid}, {31'd0, e_valid});
        check("fifo_reset_req", {31'd0, fifo_reset_req}, {31'd0, e_req});
        check("word_out", word_out, m_word);
        if (fifo_reset_req) req_seen++;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; nibble_mode = 0; lane_in = 0; frame_in = 0;
        m_mode = 0; m_slot = 0; m_run = 0; m_prev_frame = 0; m_word = 0;
        req_seen = 0;
        repeat (3) @(posedge clk);
        #2;
        tag = "R1";
        check("reset valid", {31'd0, word_valid}, 32'd0);
        check("reset req", {31'd0, fifo_reset_req}, 32'd0);
        check("reset word", word_out, 32'd0);
        rst_n = 1;

        // R2: byte order with a single-sample marker
        tag = "R2";
        step(0, 8'hA1, 1); step(0, 8'hB2, 0); step(0, 8'hC3, 0); step(0, 8'hD4, 0);
        check("byte word", word_out, 32'hA1B2C3D4);
        check("single marker no req", {31'd0, fifo_reset_req}, 32'd0);
        step(0, 8'h11, 0);
        tag = "R8";
        check("hold word", word_out, 32'hA1B2C3D4);

        // R5: a rise partway through a load realigns to the first slot
        tag = "R5";
        step(0, 8'h22, 0);
        step(0, 8'h5A, 1); step(0, 8'h6B, 0); step(0, 8'h7C, 0); step(0, 8'h8D, 0);
        check("realigned word", word_out, 32'h5A6B7C8D);

        // R6 and R7: extended frame in byte mode, then held over more loads
        tag = "R6";
        step(0, 8'h00, 0);
        step(0, 8'h00, 0); step(0, 8'h00, 0); step(0, 8'h00, 0);
        req_seen = 0;
        step(0, 8'h01, 1); step(0, 8'h02, 1); step(0, 8'h03, 1); step(0, 8'h04, 1);
        check("byte ext req", {31'd0, fifo_reset_req}, 32'd1);
        tag = "R7";
        for (int i = 0; i < 8; i++) step(0, 8'(i), 1);
        check("one req only", req_seen, 1);

        // R9: mode change discards, and a high marker across it is no rise
        tag = "R9";
        step(1, 8'hFF, 1);
        check("change no valid", {31'd0, word_valid}, 32'd0);
        step(1, 8'h00, 0);
        for (int k = 0; k < 7; k++) step(1, 8'hF0 | 8'(k + 1), 0);

        // R3: nibble order, upper lane bits ignored; R6 nibble extended frame
        tag = "R3";
        step(1, 8'h00, 0);
        req_seen = 0;
        for (int k = 0; k < 8; k++) step(1, 8'hE0 | 8'(8 - k), 1);
        check("nibble word", word_out, 32'h87654321);
        tag = "R6";
        check("nibble ext req", req_seen, 1);

        // R5: marker one sample short of a nibble load gives no request
        tag = "R5";
        step(1, 8'h0, 0);
        req_seen = 0;
        for (int k = 0; k < 7; k++) step(1, 8'(k), 1);
        for (int k = 0; k < 9; k++) step(1, 8'(k), 0);
        check("short run no req", req_seen, 0);

        // R4 R8 R9: constrained random mix
        tag = "R4";
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            bit m = ($urandom_range(0, 99) < 3) ? !m_mode : m_mode;
            bit f = ($urandom_range(0, 99) < 30);
            step(m, 8'($urandom), f);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule